// File: doc/BRIEF.md
# Signed Word-by-Halfword Iterative Divider

This unit divides a signed 32-bit dividend by a signed 16-bit divisor. The divisor is the low half of a 32-bit operand, sign-extended, and the upper half of that operand is ignored. A start strobe in the idle state captures both operands. The unit then returns a 32-bit quotient truncated toward zero, together with zero, sign and overflow flag values and a mask that names the flags a consumer should write. The carry flag is never in the mask, so the status word keeps its carry bit. No remainder is returned.

Regular operands go through a radix-2 restoring divider on magnitudes: one iteration per cycle for 32 cycles, then one cycle to apply the sign. Two operand pairs finish in the cycle after start, with fixed results and overflow set. A zero divisor yields a quotient of 0. The most negative dividend over a divisor of -1 yields 0x80000000.

The controller has four states. IDLE waits for start. From IDLE, start with special operands moves straight to DONE (load-special), and start with regular operands moves to RUN (load-regular). RUN repeats one iteration per cycle and leaves for FIX after the last one (iterate-last). FIX writes the signed result and moves to DONE (correct). DONE lasts one cycle and returns to IDLE (retire).

Top module: `hdiv_unit`

## Requirements
- R1: Only bits 15:0 of `divisor_op` are used, as a sign-extended 16-bit value. Bits 31:16 have no effect on any output.
- R2: For a non-zero divisor, except the pair in R4, `quotient` is the signed quotient truncated toward zero and `flag_ov` is 0.
- R3: A zero divisor gives `quotient` = 0 and `flag_ov` = 1.
- R4: Dividend 0x80000000 with divisor -1 (bits 15:0 = 0xFFFF) gives `quotient` = 0x80000000 and `flag_ov` = 1.
- R5: `flag_z` is 1 exactly when `quotient` is 0. `flag_s` equals `quotient` bit 31.
- R6: `flag_mask` is 4'b0111 while `done` is high and 0 otherwise. Bit 0 selects zero, bit 1 sign, bit 2 overflow and bit 3 carry, so carry is never selected.
- R7: For a regular operation, `busy` is high for the 33 cycles after the clock edge that accepts start (32 iterations and one sign cycle). `done` is high for exactly the next cycle, and `busy` and `done` are never high together.
- R8: For the operand pairs of R3 and R4, `done` is high in the cycle right after the accepting edge, and `busy` stays low.
- R9: Start is accepted only in IDLE. Start and operand changes while `busy` is high do not alter the result in progress.
- R10: `quotient` and the flag outputs hold their values from `done` until the next accepted start.
- R11: After reset, `busy`, `done`, `quotient`, the three flags and `flag_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division; accepted only in IDLE |
| dividend | input | 32 | Signed dividend |
| divisor_op | input | 32 | Divisor operand; only bits 15:0 are used |
| busy | output | 1 | Iteration or sign correction in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| quotient | output | 32 | Signed quotient, held until the next start |
| flag_z | output | 1 | Zero flag value |
| flag_s | output | 1 | Sign flag value |
| flag_ov | output | 1 | Overflow flag value |
| flag_mask | output | 4 | Flags to update: bit0 zero, bit1 sign, bit2 overflow, bit3 carry |

## Verification
The bench builds the unit with the default widths of 32 and 16. These widths make the real edge values reachable: the 0x80000000 dividend, the 0x8000 and 0x7FFF divisors, and 16-bit divisor fields placed under random upper bits. A behavioural model predicts `busy` and `done` on every clock from the 33-cycle latency. It checks the quotient and flags against integer division, and it restarts the unit with new operands in mid-run to show that the operation in flight is unaffected.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } hdiv_state_e;

    // Operand classes resolved at start
    typedef enum logic [1:0] {
        SPC_NONE     = 2'd0,
        SPC_ZERO_DIV = 2'd1,
        SPC_MIN_NEG1 = 2'd2
    } hdiv_special_e;

    // Flag vector layout shared by the unit and its consumer
    localparam int FLAG_NUM       = 4;
    localparam int FLAG_ZERO_BIT  = 0;
    localparam int FLAG_SIGN_BIT  = 1;
    localparam int FLAG_OVF_BIT   = 2;
    localparam int FLAG_CARRY_BIT = 3;

    // Flags written by a divide: all except carry
    localparam logic [FLAG_NUM-1:0] FLAG_UPD_MASK =
        (FLAG_NUM'(1) << FLAG_ZERO_BIT) |
        (FLAG_NUM'(1) << FLAG_SIGN_BIT) |
        (FLAG_NUM'(1) << FLAG_OVF_BIT);

endpackage

// File: rtl/hdiv_prep.sv
// Operand preparation: divisor sign extension, magnitudes, result sign
// and detection of the two operand pairs with fixed results.
module hdiv_prep
    import hdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 16
) (
    input  logic [DW-1:0]  dividend,
    input  logic [VW-1:0]  divisor_lo,
    output logic [DW-1:0]  dvd_mag,
    output logic [DW-1:0]  dvs_mag,
    output logic           neg_result,
    output hdiv_special_e  special
);

    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] divisor_ext;

    generate
        if (DW > VW) begin : g_extend
            assign divisor_ext = {{(DW-VW){divisor_lo[VW-1]}}, divisor_lo};
        end else begin : g_same
            assign divisor_ext = divisor_lo[DW-1:0];
        end
    endgenerate

    always_comb begin
        dvd_mag    = dividend[DW-1]    ? (~dividend + 1'b1)    : dividend;
        dvs_mag    = divisor_ext[DW-1] ? (~divisor_ext + 1'b1) : divisor_ext;
        neg_result = dividend[DW-1] ^ divisor_ext[DW-1];
        if (divisor_ext == '0) begin
            special = SPC_ZERO_DIV;
        end else if ((divisor_ext == '1) && (dividend == MOST_NEG)) begin
            special = SPC_MIN_NEG1;
        end else begin
            special = SPC_NONE;
        end
    end

endmodule

// File: rtl/hdiv_core.sv
// Radix-2 restoring divider on unsigned magnitudes, one quotient bit per step.
module hdiv_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dvd_mag,
    input  logic [DW-1:0] dvs_mag,
    output logic [DW-1:0] q_mag
);

    logic [DW-1:0] part_rem;
    logic [DW-1:0] shift_acc;
    logic [DW-1:0] dvs_r;
    logic [DW:0]   trial_in;
    logic [DW+1:0] trial_diff;
    logic          fits;

    always_comb begin
        trial_in   = {part_rem, shift_acc[DW-1]};
        trial_diff = {1'b0, trial_in} - {2'b00, dvs_r};
        fits       = ~trial_diff[DW+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_rem  <= '0;
            shift_acc <= '0;
            dvs_r     <= '0;
        end else if (load) begin
            part_rem  <= '0;
            shift_acc <= dvd_mag;
            dvs_r     <= dvs_mag;
        end else if (step) begin
            part_rem  <= fits ? trial_diff[DW-1:0] : trial_in[DW-1:0];
            shift_acc <= {shift_acc[DW-2:0], fits};
        end
    end

    assign q_mag = shift_acc;

endmodule

// File: rtl/hdiv_flags.sv
// Flag values derived from a final quotient.
module hdiv_flags
    import hdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]       q,
    input  logic                ovf,
    output logic [FLAG_NUM-1:0] flags
);

    always_comb begin
        flags                 = '0;
        flags[FLAG_ZERO_BIT]  = (q == '0);
        flags[FLAG_SIGN_BIT]  = q[DW-1];
        flags[FLAG_OVF_BIT]   = ovf;
        flags[FLAG_CARRY_BIT] = 1'b0;
    end

endmodule

// File: rtl/hdiv_unit.sv
module hdiv_unit
    import hdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DW-1:0]       dividend,
    input  logic [DW-1:0]       divisor_op,
    output logic                busy,
    output logic                done,
    output logic [DW-1:0]       quotient,
    output logic                flag_z,
    output logic                flag_s,
    output logic                flag_ov,
    output logic [FLAG_NUM-1:0] flag_mask
);

    localparam int CNT_W = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DW - 1);
    localparam logic [DW-1:0]    MOST_NEG  = {1'b1, {(DW-1){1'b0}}};

    hdiv_state_e   state, state_nx;
    hdiv_special_e special;
    logic [DW-1:0] dvd_mag, dvs_mag, q_mag;
    logic          neg_now, neg_r;
    logic [CNT_W-1:0] step_cnt;
    logic          accept, load_reg, step_en;
    logic [DW-1:0] res_q;
    logic          res_ov;
    logic [FLAG_NUM-1:0] res_flags, flag_r;
    logic [DW-1:0] quot_r;
    logic          unused_hi;

    assign unused_hi = ^divisor_op[DW-1:VW];

    hdiv_prep #(.DW(DW), .VW(VW)) u_prep (
        .dividend   (dividend),
        .divisor_lo (divisor_op[VW-1:0]),
        .dvd_mag    (dvd_mag),
        .dvs_mag    (dvs_mag),
        .neg_result (neg_now),
        .special    (special)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign load_reg = accept && (special == SPC_NONE);
    assign step_en  = (state == ST_RUN);

    hdiv_core #(.DW(DW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_reg),
        .step    (step_en),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .q_mag   (q_mag)
    );

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (special == SPC_NONE) ? ST_RUN : ST_DONE;
            ST_RUN:  if (step_cnt == LAST_STEP) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        step_cnt <= '0;
        else if (load_reg) step_cnt <= '0;
        else if (step_en)  step_cnt <= step_cnt + 1'b1;
    end

    // Result selection
    always_comb begin
        res_q  = neg_r ? (~q_mag + 1'b1) : q_mag;
        res_ov = 1'b0;
        if (state == ST_IDLE) begin
            unique case (special)
                SPC_ZERO_DIV: begin res_q = '0;       res_ov = 1'b1; end
                SPC_MIN_NEG1: begin res_q = MOST_NEG; res_ov = 1'b1; end
                default:      begin res_q = '0;       res_ov = 1'b0; end
            endcase
        end
    end

    hdiv_flags #(.DW(DW)) u_flags (
        .q     (res_q),
        .ovf   (res_ov),
        .flags (res_flags)
    );

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quot_r <= '0;
            flag_r <= '0;
            neg_r  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) neg_r <= neg_now;
                    if (accept && (special != SPC_NONE)) begin
                        quot_r <= res_q;
                        flag_r <= res_flags;
                    end
                end
                ST_FIX: begin
                    quot_r <= res_q;
                    flag_r <= res_flags;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state == ST_RUN) || (state == ST_FIX);
    assign done      = (state == ST_DONE);
    assign quotient  = quot_r;
    assign flag_z    = flag_r[FLAG_ZERO_BIT];
    assign flag_s    = flag_r[FLAG_SIGN_BIT];
    assign flag_ov   = flag_r[FLAG_OVF_BIT];
    assign flag_mask = done ? FLAG_UPD_MASK : '0;

endmodule

// File: rtl/hdiv_unit_chk.sv
module hdiv_unit_chk
    import hdiv_pkg::*;
#(
    parameter int DW = 32,
    parameter int VW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [DW-1:0]       divisor_op,
    input logic                busy,
    input logic                done,
    input logic [DW-1:0]       quotient,
    input logic                flag_z,
    input logic                flag_s,
    input logic                flag_ov,
    input logic [FLAG_NUM-1:0] flag_mask
);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6
    mask_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_mask == 4'b0111));

    // R6
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (flag_mask == '0));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (quotient == '0)));

    // R5
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_s == quotient[DW-1]));

    // R3
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && (divisor_op[VW-1:0] == '0))
        |=> (done && flag_ov && (quotient == '0)));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> ($stable(quotient) && $stable(flag_ov)));

    // R9
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

bind hdiv_unit hdiv_unit_chk #(.DW(DW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .divisor_op (divisor_op),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .flag_z     (flag_z),
    .flag_s     (flag_s),
    .flag_ov    (flag_ov),
    .flag_mask  (flag_mask)
);

// File: tb/hdiv_unit_bench.sv
module hdiv_unit_bench;

    localparam int DW  = 32;
    localparam int VW  = 16;
    localparam int LAT = DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [DW-1:0] divisor_op = '0;
    logic          busy, done, flag_z, flag_s, flag_ov;
    logic [DW-1:0] quotient;
    logic [3:0]    flag_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hdiv_unit #(.DW(DW), .VW(VW)) u_hdiv_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dividend   (dividend),
        .divisor_op (divisor_op),
        .busy       (busy),
        .done       (done),
        .quotient   (quotient),
        .flag_z     (flag_z),
        .flag_s     (flag_s),
        .flag_ov    (flag_ov),
        .flag_mask  (flag_mask)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic bit is_special(input logic [DW-1:0] a, input logic [DW-1:0] b);
        longint sd;
        sd = longint'($signed(b[VW-1:0]));
        return (sd == 0) || (sd == -1 && a == 32'h8000_0000);
    endfunction

    function automatic logic [DW-1:0] ref_q(input logic [DW-1:0] a, input logic [DW-1:0] b);
        longint sa, sd, q;
        sa = longint'($signed(a));
        sd = longint'($signed(b[VW-1:0]));
        if (sd == 0)                         q = 0;
        else if (sd == -1 && sa == -(64'sd1 <<< 31)) q = -(64'sd1 <<< 31);
        else                                 q = sa / sd;
        return q[DW-1:0];
    endfunction

    // One operation, compared against the model on every clock
    task automatic do_op(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit noise);
        logic [DW-1:0] eq;
        bit sp;
        int dj;
        eq = ref_q(a, b);
        sp = is_special(a, b);
        dj = sp ? 0 : LAT;
        @(negedge clk);
        start = 1'b1; dividend = a; divisor_op = b;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= dj + 2; j++) begin
            bit eb, ed;
            eb = !sp && (j < dj);
            ed = (j == dj);
            check(busy == eb, sp ? "R8" : "R7", "busy", 32'(busy), 32'(eb));
            check(done == ed, sp ? "R8" : "R7", "done", 32'(done), 32'(ed));
            check(flag_mask == (ed ? 4'b0111 : 4'b0000), "R6", "mask",
                  32'(flag_mask), ed ? 32'h7 : 32'h0);
            if (j >= dj) begin
                string rq;
                rq = (j > dj) ? "R10" : (b[VW-1:0] == '0) ? "R3" : sp ? "R4" : "R2";
                check(quotient == eq, rq, "quotient", quotient, eq);
                check(flag_ov == sp, rq, "overflow", 32'(flag_ov), 32'(sp));
                check(flag_z == (eq == '0), "R5", "zero", 32'(flag_z), 32'(eq == '0));
                check(flag_s == eq[DW-1], "R5", "sign", 32'(flag_s), 32'(eq[DW-1]));
            end
            if (noise && !sp && j == 5) begin   // R9 restart attempt mid-run
                start = 1'b1; dividend = $urandom; divisor_op = $urandom | 32'h1;
            end
            if (noise && !sp && j == 12) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'(checks), 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 1'b0, "R11", "busy", 32'(busy), 32'h0);
        check(done == 1'b0, "R11", "done", 32'(done), 32'h0);
        check(quotient == '0, "R11", "quotient", quotient, 32'h0);
        check({flag_z, flag_s, flag_ov} == 3'b000, "R11", "flags",
              32'({flag_z, flag_s, flag_ov}), 32'h0);
        check(flag_mask == 4'b0, "R11", "mask", 32'(flag_mask), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 regular signs and truncation
        do_op(32'd100, 32'd7, 1'b0);
        do_op(-32'sd100, 32'd7, 1'b0);
        do_op(32'd100, 32'h0000_FFF9, 1'b0);
        do_op(-32'sd7, 32'h0000_FFF9, 1'b0);
        do_op(32'd3, 32'd5, 1'b0);
        // R3 zero divisor, also with upper bits set (R1)
        do_op(32'h1234_5678, 32'h0000_0000, 1'b0);
        do_op(32'h8000_0000, 32'hFFFF_0000, 1'b0);
        // R4 most negative by -1, divisor upper bits irrelevant (R1)
        do_op(32'h8000_0000, 32'h0000_FFFF, 1'b0);
        do_op(32'h8000_0000, 32'h0001_FFFF, 1'b0);
        do_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        // most negative dividend with edge divisors
        do_op(32'h8000_0000, 32'h0000_0001, 1'b0);
        do_op(32'h8000_0000, 32'h0000_8000, 1'b0);
        do_op(32'h8000_0000, 32'h0000_7FFF, 1'b0);
        do_op(32'h7FFF_FFFF, 32'h0000_8000, 1'b0);
        do_op(32'h7FFF_FFFF, 32'h0000_7FFF, 1'b0);
        // R1 upper operand bits ignored
        do_op(32'd1000, 32'hABCD_0003, 1'b0);
        do_op(32'd1000, 32'h1234_FFFE, 1'b0);
        // R9 start during busy ignored
        do_op(32'hDEAD_BEEF, 32'h0000_0123, 1'b1);
        do_op(-32'sd12345, 32'h5555_0010, 1'b1);
        // random operands
        for (int k = 0; k < 60; k++) begin
            logic [DW-1:0] ra, rb;
            ra = $urandom;
            rb = (k % 3 == 0) ? (32'($urandom % 256) - 32'd128) : $urandom;
            do_op(ra, rb, k % 4 == 1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule